// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block is the hardware part of taking an external interrupt in a small 32-bit processor with mixed 16-bit and 32-bit instructions. At every retiring instruction it decides whether the instruction break is a legal place to accept a request. A break is legal only when the next instruction address is word aligned and the retiring instruction is not a 16-bit non-branch that started on a word boundary. An accepted request also needs the interrupt enable flag set.

On acceptance the block performs the whole entry in one clock edge. The mode, enable and carry flags are copied into their backup flags and then cleared. The word-aligned break address is stored in the backup PC. A fetch address equal to the interrupt vector is presented with a one-cycle entry pulse, so the fetch stage can flush. The vector is the normal entry address unless the flash program/erase mode is active, in which case it is the on-chip RAM entry address.

The block owns the three status flags. The execute stage updates them through a load port. A request seen while the enable flag is clear is held until a legal break occurs with the flag set.

Top module: `irq_entry_seq`

## Requirements
- R1: During synchronous active-low reset, all status flags, backup flags, the backup PC, the fetch address and the entry pulse are cleared to 0.
- R2: On entry, the backup flags take the flag values that are in force at the break: the loaded values if a flag load happens in the same cycle, otherwise the stored ones. The backup enable flag therefore reads 1.
- R3: In the cycle after entry, the mode, enable and carry flags all read 0.
- R4: On entry, the backup PC holds the break address (the next instruction address) with its two low bits equal to 0.
- R5: With the flash mode input low at acceptance, the fetch address after entry is 0x0000_0080.
- R6: With the flash mode input high at acceptance, the fetch address after entry is 0x0080_4000.
- R7: No entry occurs at a break whose next instruction address has bit 1 set.
- R8: No entry occurs after a 16-bit instruction (length flag 0) whose address bit 1 is 0 and whose branch flag is 0, even when the next address is aligned.
- R9: A 16-bit branch starting on a word boundary, with a word-aligned target, is a legal break. The request is accepted there.
- R10: A request seen while the enable flag is 0 is held. It is accepted at the first legal break with the enable flag 1, even if the request line has dropped.
- R11: The entry pulse lasts one cycle, and all flag, backup, PC and fetch address updates appear in that same cycle.
- R12: No entry occurs in a cycle without a retiring instruction.
- R13: A flag load without entry sets the flags to the loaded values on the next cycle and leaves the backups unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req_i | input | 1 | Interrupt request from the interrupt controller |
| retire_valid_i | input | 1 | An instruction retires this cycle |
| retire_pc_lo_i | input | 2 | Low address bits of the retiring instruction |
| retire_len32_i | input | 1 | Retiring instruction is 32 bits (0 means 16 bits) |
| retire_branch_i | input | 1 | Retiring instruction is a taken branch |
| next_pc_i | input | 32 | Address of the next instruction (the break point) |
| flash_pe_i | input | 1 | Flash program/erase mode active |
| psw_load_i | input | 1 | Execute stage writes the flags this cycle |
| psw_new_i | input | 3 | New flags {mode, enable, carry} |
| sm_o | output | 1 | Mode flag |
| ie_o | output | 1 | Interrupt enable flag |
| c_o | output | 1 | Carry flag |
| bsm_o | output | 1 | Backup mode flag |
| bie_o | output | 1 | Backup enable flag |
| bc_o | output | 1 | Backup carry flag |
| bpc_o | output | 32 | Backup PC |
| entry_o | output | 1 | One-cycle entry pulse |
| fetch_addr_o | output | 32 | Redirected fetch address, valid with entry_o |

## Verification
The bench builds the block with its defaults: a 32-bit address, 4-byte words and the two standard vectors. With the word size at 4, the only alignment bits are the two low address bits. This makes it possible to sweep every combination of start-address bit 1, instruction length, branch flag, break-address bit 1, enable flag, flash mode and request line, with distinct flag values in each case. Separate sequences cover the held request across a disabled period, a flag load that coincides with acceptance, and the one-cycle length of the entry pulse.

// File: rtl/irq_entry_pkg.sv
// Package: shared flag type for the interrupt entry sequencer.
// Assumes the flag word is ordered {mode, enable, carry}.
package irq_entry_pkg;

    typedef struct packed {
        logic sm;
        logic ie;
        logic c;
    } psw_t;

    localparam psw_t PSW_CLEAR = '{sm: 1'b0, ie: 1'b0, c: 1'b0};

endpackage

// File: rtl/irq_boundary_gate.sv
// Module: decides whether the current retiring instruction leaves a break
// at which an interrupt may be accepted.
// Assumes instructions are either one halfword or one word long, and that
// the caller gives the low address bits of the retiring instruction.
module irq_boundary_gate #(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned WORD_BYTES = 4
) (
    input  logic                  retire_valid_i,
    input  logic [$clog2(WORD_BYTES)-1:0] pc_lo_i,
    input  logic                  len32_i,
    input  logic                  branch_i,
    input  logic [ADDR_W-1:0]     next_pc_i,
    output logic                  legal_o
);

    localparam int unsigned ALIGN_BITS = $clog2(WORD_BYTES);

    logic brk_aligned;
    logic start_aligned;
    logic short_block;

    // Classify the break and the retiring instruction.
    always_comb begin
        brk_aligned   = (next_pc_i[ALIGN_BITS-1:0] == '0);
        start_aligned = (pc_lo_i == '0);
        short_block   = !len32_i && start_aligned && !branch_i;
        legal_o       = retire_valid_i && brk_aligned && !short_block;
    end

endmodule

// File: rtl/irq_pending_latch.sv
// Module: remembers an interrupt request until it is taken.
// Assumes the request may drop before acceptance. Taking it clears the
// held copy.
module irq_pending_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic take_i,
    output logic pend_o
);

    logic held_q;

    // Present a request that is either new this cycle or held from before.
    always_comb begin
        pend_o = held_q || req_i;
    end

    // Hold the request until the entry consumes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= 1'b0;
        end else if (take_i) begin
            held_q <= 1'b0;
        end else begin
            held_q <= pend_o;
        end
    end

    // R10: an entry is only taken while a request is outstanding
    a_r10_take_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |-> pend_o);

endmodule

// File: rtl/irq_entry_regs.sv
// Module: status flags, backup flags, backup PC and fetch redirect.
// Does the whole entry in one edge. Assumes accept_i is only raised when
// the effective enable flag is 1.
module irq_entry_regs
    import irq_entry_pkg::*;
#(
    parameter int unsigned     ADDR_W     = 32,
    parameter int unsigned     WORD_BYTES = 4,
    parameter logic [ADDR_W-1:0] VEC_NORMAL = 'h0000_0080,
    parameter logic [ADDR_W-1:0] VEC_FLASH  = 'h0080_4000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psw_load_i,
    input  psw_t              psw_new_i,
    input  logic              accept_i,
    input  logic              flash_i,
    input  logic [ADDR_W-1:0] brk_pc_i,
    output psw_t              eff_psw_o,
    output psw_t              psw_o,
    output psw_t              bpsw_o,
    output logic [ADDR_W-1:0] bpc_o,
    output logic              entry_o,
    output logic [ADDR_W-1:0] fetch_o
);

    localparam int unsigned ALIGN_BITS = $clog2(WORD_BYTES);

    psw_t              psw_q;
    psw_t              bpsw_q;
    logic [ADDR_W-1:0] bpc_q;
    logic [ADDR_W-1:0] fetch_q;
    logic              entry_q;
    logic [ADDR_W-1:0] vec_sel;

    // Flags in force at the break: a same-cycle load has already happened.
    always_comb begin
        eff_psw_o = psw_load_i ? psw_new_i : psw_q;
        vec_sel   = flash_i ? VEC_FLASH : VEC_NORMAL;
    end

    // Flag register: cleared on entry, otherwise follows the load port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psw_q <= PSW_CLEAR;
        end else if (accept_i) begin
            psw_q <= PSW_CLEAR;
        end else if (psw_load_i) begin
            psw_q <= psw_new_i;
        end
    end

    // Backup flags and backup PC: captured only on entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bpsw_q <= PSW_CLEAR;
            bpc_q  <= '0;
        end else if (accept_i) begin
            bpsw_q <= eff_psw_o;
            bpc_q  <= {brk_pc_i[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
        end
    end

    // Fetch redirect and the entry pulse, the last step of the entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_q <= '0;
            entry_q <= 1'b0;
        end else begin
            entry_q <= accept_i;
            if (accept_i) begin
                fetch_q <= vec_sel;
            end
        end
    end

    assign psw_o   = psw_q;
    assign bpsw_o  = bpsw_q;
    assign bpc_o   = bpc_q;
    assign entry_o = entry_q;
    assign fetch_o = fetch_q;

    // R3: flags read clear in the entry cycle
    a_r3_flags_clear: assert property (@(posedge clk) disable iff (!rst_n)
        entry_q |-> (psw_q == PSW_CLEAR));

    // R2: the backed-up enable flag must have been 1
    a_r2_bie_set: assert property (@(posedge clk) disable iff (!rst_n)
        entry_q |-> bpsw_q.ie);

    // R4: saved PC is word aligned
    a_r4_bpc_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        entry_q |-> (bpc_q[ALIGN_BITS-1:0] == '0));

    // R5/R6: fetch address matches the mode seen at acceptance
    a_r6_vector: assert property (@(posedge clk) disable iff (!rst_n)
        entry_q |-> (fetch_q == ($past(flash_i) ? VEC_FLASH : VEC_NORMAL)));

    // R13: a plain load lands in the flags and leaves the backups alone
    a_r13_load: assert property (@(posedge clk) disable iff (!rst_n)
        (psw_load_i && !accept_i) |=> ((psw_q == $past(psw_new_i)) && $stable(bpsw_q)));

endmodule

// File: rtl/irq_entry_seq.sv
// Module: top of the interrupt entry sequencer.
// Joins the break classifier, the pending request holder and the entry
// registers. Assumes one retiring instruction per cycle at most.
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter int unsigned       ADDR_W     = 32,
    parameter int unsigned       WORD_BYTES = 4,
    parameter logic [ADDR_W-1:0] VEC_NORMAL = 'h0000_0080,
    parameter logic [ADDR_W-1:0] VEC_FLASH  = 'h0080_4000
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          irq_req_i,
    input  logic                          retire_valid_i,
    input  logic [$clog2(WORD_BYTES)-1:0] retire_pc_lo_i,
    input  logic                          retire_len32_i,
    input  logic                          retire_branch_i,
    input  logic [ADDR_W-1:0]             next_pc_i,
    input  logic                          flash_pe_i,
    input  logic                          psw_load_i,
    input  logic [2:0]                    psw_new_i,
    output logic                          sm_o,
    output logic                          ie_o,
    output logic                          c_o,
    output logic                          bsm_o,
    output logic                          bie_o,
    output logic                          bc_o,
    output logic [ADDR_W-1:0]             bpc_o,
    output logic                          entry_o,
    output logic [ADDR_W-1:0]             fetch_addr_o
);

    logic legal;
    logic pend;
    logic accept;
    psw_t eff_psw;
    psw_t psw;
    psw_t bpsw;
    psw_t psw_new;

    assign psw_new = psw_t'(psw_new_i);

    irq_boundary_gate #(
        .ADDR_W     (ADDR_W),
        .WORD_BYTES (WORD_BYTES)
    ) u_gate (
        .retire_valid_i (retire_valid_i),
        .pc_lo_i        (retire_pc_lo_i),
        .len32_i        (retire_len32_i),
        .branch_i       (retire_branch_i),
        .next_pc_i      (next_pc_i),
        .legal_o        (legal)
    );

    irq_pending_latch u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (irq_req_i),
        .take_i (accept),
        .pend_o (pend)
    );

    // Accept a request at a legal break while the effective enable is set.
    always_comb begin
        accept = legal && pend && eff_psw.ie;
    end

    irq_entry_regs #(
        .ADDR_W     (ADDR_W),
        .WORD_BYTES (WORD_BYTES),
        .VEC_NORMAL (VEC_NORMAL),
        .VEC_FLASH  (VEC_FLASH)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .psw_load_i (psw_load_i),
        .psw_new_i  (psw_new),
        .accept_i   (accept),
        .flash_i    (flash_pe_i),
        .brk_pc_i   (next_pc_i),
        .eff_psw_o  (eff_psw),
        .psw_o      (psw),
        .bpsw_o     (bpsw),
        .bpc_o      (bpc_o),
        .entry_o    (entry_o),
        .fetch_o    (fetch_addr_o)
    );

    assign sm_o  = psw.sm;
    assign ie_o  = psw.ie;
    assign c_o   = psw.c;
    assign bsm_o = bpsw.sm;
    assign bie_o = bpsw.ie;
    assign bc_o  = bpsw.c;

    // R12: every entry follows a retiring instruction
    a_r12_entry_at_retire: assert property (@(posedge clk) disable iff (!rst_n)
        entry_o |-> $past(retire_valid_i));

    // R7: the break behind an entry was word aligned
    a_r7_break_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        entry_o |-> ($past(next_pc_i[1:0]) == 2'b00));

    // R8: a 16-bit non-branch from a word boundary never leads to entry
    a_r8_short_block: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_valid_i && !retire_len32_i && !retire_branch_i && (retire_pc_lo_i == '0))
        |=> !entry_o);

endmodule

// File: tb/tb_irq_entry_seq.sv
module tb_irq_entry_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_req_i = 1'b0;
    logic        retire_valid_i = 1'b0;
    logic [1:0]  retire_pc_lo_i = 2'b00;
    logic        retire_len32_i = 1'b0;
    logic        retire_branch_i = 1'b0;
    logic [31:0] next_pc_i = '0;
    logic        flash_pe_i = 1'b0;
    logic        psw_load_i = 1'b0;
    logic [2:0]  psw_new_i = 3'b000;
    logic        sm_o, ie_o, c_o, bsm_o, bie_o, bc_o, entry_o;
    logic [31:0] bpc_o, fetch_addr_o;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    irq_entry_seq dut (
        .clk (clk), .rst_n (rst_n), .irq_req_i (irq_req_i),
        .retire_valid_i (retire_valid_i), .retire_pc_lo_i (retire_pc_lo_i),
        .retire_len32_i (retire_len32_i), .retire_branch_i (retire_branch_i),
        .next_pc_i (next_pc_i), .flash_pe_i (flash_pe_i),
        .psw_load_i (psw_load_i), .psw_new_i (psw_new_i),
        .sm_o (sm_o), .ie_o (ie_o), .c_o (c_o),
        .bsm_o (bsm_o), .bie_o (bie_o), .bc_o (bc_o),
        .bpc_o (bpc_o), .entry_o (entry_o), .fetch_addr_o (fetch_addr_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        retire_valid_i = 0; psw_load_i = 0; irq_req_i = 0;
    endtask

    task automatic do_reset();
        idle();
        rst_n = 0;
        tick(); tick();
        rst_n = 1;
    endtask

    task automatic load_psw(input logic [2:0] v);
        psw_load_i = 1; psw_new_i = v; retire_valid_i = 0; irq_req_i = 0;
        tick();
        psw_load_i = 0;
    endtask

    task automatic retire(input logic [1:0] lo, input logic l32, input logic br, input logic [31:0] npc);
        retire_valid_i = 1; retire_pc_lo_i = lo; retire_len32_i = l32;
        retire_branch_i = br; next_pc_i = npc;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state after loading non-zero flags
        tick();
        rst_n = 1;
        load_psw(3'b111);
        retire(2'b00, 1, 0, 32'h100); irq_req_i = 1; flash_pe_i = 1;
        tick();
        do_reset();
        chk("R1 flags", {29'd0, sm_o, ie_o, c_o}, 32'd0);
        chk("R1 backups", {29'd0, bsm_o, bie_o, bc_o}, 32'd0);
        chk("R1 bpc", bpc_o, 32'd0);
        chk("R1 fetch", fetch_addr_o, 32'd0);
        chk("R1 entry", {31'd0, entry_o}, 32'd0);

        // Sweep of every break shape, flag value, mode and request state
        for (int i = 0; i < 128; i++) begin
            logic pc1, l32, br, np1, ie, fl, rq, sm, cc, acc;
            logic [31:0] npc, vec;
            string tag;
            pc1 = i[0]; l32 = i[1]; br = i[2]; np1 = i[3];
            ie = i[4]; fl = i[5]; rq = i[6];
            sm = i[1] ^ i[5]; cc = i[0] | i[3];
            npc = 32'h0001_0000 + 32'(i) * 32'h40 + {30'd0, np1, 1'b0};
            vec = fl ? 32'h0080_4000 : 32'h0000_0080;
            acc = rq && ie && !np1 && !(!l32 && !pc1 && !br);
            if (!rq || !ie) tag = "R10 gate";
            else if (np1) tag = "R7 unaligned break";
            else if (!l32 && !pc1 && !br) tag = "R8 short block";
            else if (!l32 && !pc1 && br) tag = "R9 short branch";
            else tag = "R11 entry";
            do_reset();
            load_psw({sm, ie, cc});
            chk("R13 load", {29'd0, sm_o, ie_o, c_o}, {29'd0, sm, ie, cc});
            retire({pc1, 1'b0}, l32, br, npc); irq_req_i = rq; flash_pe_i = fl;
            tick();
            idle();
            chk(tag, {31'd0, entry_o}, {31'd0, acc});
            if (acc) begin
                chk("R3 flags cleared", {29'd0, sm_o, ie_o, c_o}, 32'd0);
                chk("R2 backups", {29'd0, bsm_o, bie_o, bc_o}, {29'd0, sm, ie, cc});
                chk("R4 bpc", bpc_o, npc);
                chk(fl ? "R6 flash vector" : "R5 normal vector", fetch_addr_o, vec);
            end else begin
                chk("R13 flags held", {29'd0, sm_o, ie_o, c_o}, {29'd0, sm, ie, cc});
                chk("R13 backups untouched", {29'd0, bsm_o, bie_o, bc_o}, 32'd0);
            end
        end

        // R10: request held across a disabled period, taken after enable
        do_reset();
        flash_pe_i = 0;
        retire(2'b00, 1, 0, 32'h0000_3000); irq_req_i = 1;
        tick();
        idle();
        chk("R10 no entry while disabled", {31'd0, entry_o}, 32'd0);
        tick();
        load_psw(3'b011);
        chk("R12 no entry without retire", {31'd0, entry_o}, 32'd0);
        retire(2'b10, 0, 0, 32'h0000_3004);
        tick();
        idle();
        chk("R10 held request taken", {31'd0, entry_o}, 32'd1);
        chk("R4 held bpc", bpc_o, 32'h0000_3004);
        chk("R2 held backups", {29'd0, bsm_o, bie_o, bc_o}, 32'd3);
        tick();
        chk("R11 pulse ends", {31'd0, entry_o}, 32'd0);
        chk("R11 fetch kept", fetch_addr_o, 32'h0000_0080);
        load_psw(3'b010);
        retire(2'b00, 1, 0, 32'h0000_3008);
        tick();
        idle();
        chk("R10 request consumed", {31'd0, entry_o}, 32'd0);

        // R2: flag load in the acceptance cycle is what gets backed up
        do_reset();
        retire(2'b00, 1, 0, 32'h0000_4000); irq_req_i = 1;
        psw_load_i = 1; psw_new_i = 3'b110; flash_pe_i = 1;
        tick();
        idle();
        chk("R2 coincident entry", {31'd0, entry_o}, 32'd1);
        chk("R2 coincident backups", {29'd0, bsm_o, bie_o, bc_o}, 32'd6);
        chk("R3 coincident flags", {29'd0, sm_o, ie_o, c_o}, 32'd0);
        chk("R6 coincident vector", fetch_addr_o, 32'h0080_4000);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule